// File: doc/BRIEF.md
# DDR Write Burst Strobe Sequencer

This block is the controller-side engine that sends one write burst to a double-data-rate mobile DRAM. It runs on a tick clock that is twice the memory clock and produces that memory clock itself on `mem_ck`. A write command carries a bank and a column. It is taken only on a tick where `mem_ck` is high and no burst is in flight. From then on the block handles the whole burst.

The block first drives the strobe low for one tick as a preamble. It then moves one data word and its byte mask per tick, which gives two beats per memory clock with the strobe toggling once per beat. After the last beat it drives the strobe low for one more tick as a postamble. Finally it drops every output enable so the pins float. Write data comes from a simple ready stream: each tick with `wr_ready` high takes one word and one mask at the rising edge that ends the tick.

The burst length is held in a small mode register and can only be 2, 4 or 8 beats. Column addresses inside a burst advance in order and wrap within the block aligned to the burst length.

Top module: `ddr_wr_seq`

## Requirements
- R1: The burst-length register is written when `mode_we` is high. Code 3'b001 selects 2 beats, 3'b010 selects 4 and 3'b011 selects 8. Any other code leaves the previous setting. After reset the setting is 4 beats. A burst uses the setting in force at its acceptance tick.
- R2: `mem_ck` toggles every tick. A command (`cmd_wr` high) is accepted only on a tick where `mem_ck` is high and the block is idle. `busy` is high from the tick after acceptance through the postamble tick.
- R3: The first beat is driven in the second tick after the acceptance tick, one memory clock later, while `mem_ck` is high. Beats follow on consecutive ticks. During beat k, `dq_oe` is high, and `dqs_o` is 1 for even k and 0 for odd k.
- R4: In the tick right after acceptance, `dqs_oe` is 1, `dqs_o` is 0 and `dq_oe` is 0. This is the preamble.
- R5: In the tick after the last beat, `dqs_oe` is 1, `dqs_o` is 0 and `dq_oe` is 0. This is the postamble. In the tick after the postamble, `dqs_oe`, `dq_oe` and `dm_oe` are all 0.
- R6: Beat k drives the k-th data word and the k-th mask taken from the stream on `dq_o` and `dm_o`. `dm_oe` follows `dq_oe`.
- R7: `wr_ready` is high for exactly the burst length in ticks, starting with the preamble tick. It is never high while `busy` is low.
- R8: During beat k, `beat_col` = (C & ~(BL-1)) | ((C + k) & (BL-1)), where C is the column and BL the burst length captured at acceptance. `beat_bank` holds the bank captured at acceptance.
- R9: A command presented while a burst is active, or on a tick where `mem_ck` is low, is ignored. It changes neither the running burst nor its address.
- R10: `done` is high for exactly the one tick after the postamble, with `busy` low in that tick.
- R11: During and after reset, all output enables, `busy`, `done` and `wr_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the memory clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Burst-length register write strobe |
| mode_bl_code | input | 3 | Burst-length code |
| cmd_wr | input | 1 | Write command request |
| cmd_bank | input | BANK_W | Bank of the write command |
| cmd_col | input | COL_W | Start column of the write command |
| wr_data | input | DQ_W | Write data word for the next beat |
| wr_mask | input | DQ_W/8 | Byte mask for the next beat |
| wr_ready | output | 1 | Word and mask taken at the end of this tick |
| mem_ck | output | 1 | Generated memory clock |
| dq_o | output | DQ_W | Data pin value |
| dq_oe | output | 1 | Data pin output enable |
| dm_o | output | DQ_W/8 | Mask pin value |
| dm_oe | output | 1 | Mask pin output enable |
| dqs_o | output | 1 | Strobe pin value |
| dqs_oe | output | 1 | Strobe pin output enable |
| beat_col | output | COL_W | Column of the current beat |
| beat_bank | output | BANK_W | Bank of the current burst |
| busy | output | 1 | Burst in flight |
| done | output | 1 | One-tick burst completion pulse |

## Verification
Bursts run at the reset length of 4 and at lengths 8 and 2. Start columns are chosen aligned, mid-block and at the last slot of a block, so the wrap in the column order can be told apart from a plain increment or a missing block mask. Invalid length codes are written between bursts, and the next burst is checked to still have the old length. Commands are also held high through a whole burst with a different address, and one is offered on a low `mem_ck` tick; this separates correct rejection from an accidental restart or address overwrite. Back-to-back bursts confirm that the release and done ticks line up before the next acceptance.

// File: rtl/ddr_wr_pkg.sv
package ddr_wr_pkg;

  typedef enum logic [1:0] {
    BL_SEL_2 = 2'd0,
    BL_SEL_4 = 2'd1,
    BL_SEL_8 = 2'd2
  } bl_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_BEAT = 3'd2,
    ST_POST = 3'd3,
    ST_FIN  = 3'd4
  } frame_st_e;

  localparam logic [2:0] CODE_BL2 = 3'b001;
  localparam logic [2:0] CODE_BL4 = 3'b010;
  localparam logic [2:0] CODE_BL8 = 3'b011;

  function automatic logic code_ok(input logic [2:0] code);
    return (code == CODE_BL2) || (code == CODE_BL4) || (code == CODE_BL8);
  endfunction

  function automatic bl_sel_e code_sel(input logic [2:0] code);
    case (code)
      CODE_BL2: return BL_SEL_2;
      CODE_BL8: return BL_SEL_8;
      default:  return BL_SEL_4;
    endcase
  endfunction

  function automatic logic [3:0] sel_beats(input bl_sel_e sel);
    case (sel)
      BL_SEL_2: return 4'd2;
      BL_SEL_8: return 4'd8;
      default:  return 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/ddr_wr_blreg.sv
module ddr_wr_blreg
  import ddr_wr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [2:0] mode_code,
  output bl_sel_e    bl_sel
);

  bl_sel_e sel_q;
  bl_sel_e sel_d;
  logic    upd_en;

  assign upd_en = mode_we && code_ok(mode_code);

  always_comb begin
    sel_d = sel_q;
    if (upd_en) sel_d = code_sel(mode_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= BL_SEL_4;
    else        sel_q <= sel_d;
  end

  assign bl_sel = sel_q;

endmodule

// File: rtl/ddr_wr_frame.sv
module ddr_wr_frame
  import ddr_wr_pkg::*;
#(
  parameter int MAX_BL = 8,
  localparam int CNT_W = $clog2(MAX_BL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  bl_sel_e          bl_sel,
  output logic             accept,
  output logic             mem_ck,
  output logic             wr_ready,
  output logic             busy,
  output logic             done,
  output logic             dq_oe,
  output logic             dqs_o,
  output logic             dqs_oe,
  output logic [CNT_W-1:0] beat_idx,
  output logic [CNT_W-1:0] burst_mask
);

  frame_st_e        st_q, st_d;
  logic             ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_q, last_d;
  logic             at_last;

  assign at_last = (cnt_q == last_q);
  assign accept  = cmd_wr && !ph_q && (st_q == ST_IDLE);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    ph_d   = ~ph_q;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d   = ST_PRE;
          cnt_d  = '0;
          last_d = CNT_W'(sel_beats(bl_sel) - 4'd1);
        end
      end
      ST_PRE:  st_d = ST_BEAT;
      ST_BEAT: begin
        if (at_last) st_d = ST_POST;
        else         cnt_d = cnt_q + 1'b1;
      end
      ST_POST: st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  assign mem_ck     = ~ph_q;
  assign busy       = (st_q == ST_PRE) || (st_q == ST_BEAT) || (st_q == ST_POST);
  assign wr_ready   = (st_q == ST_PRE) || ((st_q == ST_BEAT) && !at_last);
  assign dq_oe      = (st_q == ST_BEAT);
  assign dqs_oe     = busy;
  assign dqs_o      = (st_q == ST_BEAT) && !cnt_q[0];
  assign done       = (st_q == ST_FIN);
  assign beat_idx   = cnt_q;
  assign burst_mask = last_q;

endmodule

// File: rtl/ddr_wr_colgen.sv
module ddr_wr_colgen #(
  parameter int COL_W = 10,
  parameter int CNT_W = 3
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [CNT_W-1:0] beat_idx,
  input  logic [CNT_W-1:0] burst_mask,
  output logic [COL_W-1:0] beat_col
);

  localparam int PAD_W = COL_W - CNT_W;

  logic [COL_W-1:0] mask_w;
  logic [COL_W-1:0] step_w;
  logic [COL_W-1:0] sum_w;

  assign mask_w   = {{PAD_W{1'b0}}, burst_mask};
  assign step_w   = {{PAD_W{1'b0}}, beat_idx};
  assign sum_w    = base_col + step_w;
  assign beat_col = (base_col & ~mask_w) | (sum_w & mask_w);

endmodule

// File: rtl/ddr_wr_datapath.sv
module ddr_wr_datapath #(
  parameter int DQ_W   = 16,
  parameter int COL_W  = 10,
  parameter int BANK_W = 2,
  localparam int DM_W  = DQ_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              load,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [DQ_W-1:0]   wr_data,
  input  logic [DM_W-1:0]   wr_mask,
  output logic [DQ_W-1:0]   dq_o,
  output logic [DM_W-1:0]   dm_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  base_col
);

  logic [DQ_W-1:0]   dq_q, dq_d;
  logic [DM_W-1:0]   dm_q, dm_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [COL_W-1:0]  col_q, col_d;

  always_comb begin
    dq_d   = dq_q;
    dm_d   = dm_q;
    bank_d = bank_q;
    col_d  = col_q;
    if (load) begin
      dq_d = wr_data;
      dm_d = wr_mask;
    end
    if (accept) begin
      bank_d = cmd_bank;
      col_d  = cmd_col;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_q   <= '0;
      dm_q   <= '0;
      bank_q <= '0;
      col_q  <= '0;
    end else begin
      dq_q   <= dq_d;
      dm_q   <= dm_d;
      bank_q <= bank_d;
      col_q  <= col_d;
    end
  end

  assign dq_o     = dq_q;
  assign dm_o     = dm_q;
  assign bank_o   = bank_q;
  assign base_col = col_q;

endmodule

// File: rtl/ddr_wr_seq.sv
module ddr_wr_seq
  import ddr_wr_pkg::*;
#(
  parameter int DQ_W        = 16,
  parameter int COL_W       = 10,
  parameter int BANK_W      = 2,
  parameter int MAX_BL      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [2:0]        mode_bl_code,
  input  logic              cmd_wr,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [DQ_W-1:0]   wr_data,
  input  logic [DQ_W/8-1:0] wr_mask,
  output logic              wr_ready,
  output logic              mem_ck,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe,
  output logic [DQ_W/8-1:0] dm_o,
  output logic              dm_oe,
  output logic              dqs_o,
  output logic              dqs_oe,
  output logic [COL_W-1:0]  beat_col,
  output logic [BANK_W-1:0] beat_bank,
  output logic              busy,
  output logic              done
);

  localparam int CNT_W = $clog2(MAX_BL);

  logic [SYNC_STAGES-1:0] rst_sh;
  logic                   rst_int_n;
  bl_sel_e                bl_sel;
  logic                   accept;
  logic [CNT_W-1:0]       beat_idx;
  logic [CNT_W-1:0]       burst_mask;
  logic [COL_W-1:0]       base_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sh[SYNC_STAGES-1];

  ddr_wr_blreg u_blreg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mode_we   (mode_we),
    .mode_code (mode_bl_code),
    .bl_sel    (bl_sel)
  );

  ddr_wr_frame #(.MAX_BL(MAX_BL)) u_frame (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cmd_wr     (cmd_wr),
    .bl_sel     (bl_sel),
    .accept     (accept),
    .mem_ck     (mem_ck),
    .wr_ready   (wr_ready),
    .busy       (busy),
    .done       (done),
    .dq_oe      (dq_oe),
    .dqs_o      (dqs_o),
    .dqs_oe     (dqs_oe),
    .beat_idx   (beat_idx),
    .burst_mask (burst_mask)
  );

  ddr_wr_datapath #(.DQ_W(DQ_W), .COL_W(COL_W), .BANK_W(BANK_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .accept   (accept),
    .load     (wr_ready),
    .cmd_bank (cmd_bank),
    .cmd_col  (cmd_col),
    .wr_data  (wr_data),
    .wr_mask  (wr_mask),
    .dq_o     (dq_o),
    .dm_o     (dm_o),
    .bank_o   (beat_bank),
    .base_col (base_col)
  );

  ddr_wr_colgen #(.COL_W(COL_W), .CNT_W(CNT_W)) u_col (
    .base_col   (base_col),
    .beat_idx   (beat_idx),
    .burst_mask (burst_mask),
    .beat_col   (beat_col)
  );

  assign dm_oe = dq_oe;

endmodule

// File: rtl/ddr_wr_seq_chk.sv
module ddr_wr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_wr,
  input logic mem_ck,
  input logic busy,
  input logic done,
  input logic wr_ready,
  input logic dq_oe,
  input logic dqs_o,
  input logic dqs_oe
);

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_wr && mem_ck));

  // R4
  preamble_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(dqs_oe && !dqs_o && !dq_oe));

  // R3
  data_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (dqs_oe && busy));

  // R5
  release_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dqs_oe) |-> ($past(!dqs_o && !dq_oe) && !dq_oe));

  // R7
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> busy);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !dqs_oe && $past(busy)));

endmodule

bind ddr_wr_seq ddr_wr_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_wr   (cmd_wr),
  .mem_ck   (mem_ck),
  .busy     (busy),
  .done     (done),
  .wr_ready (wr_ready),
  .dq_oe    (dq_oe),
  .dqs_o    (dqs_o),
  .dqs_oe   (dqs_oe)
);

// File: tb/ddr_wr_seq_tb.sv
module ddr_wr_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        mode_we;
  logic [2:0]  mode_bl_code;
  logic        cmd_wr;
  logic [1:0]  cmd_bank;
  logic [9:0]  cmd_col;
  logic [15:0] wr_data;
  logic [1:0]  wr_mask;
  logic        wr_ready, mem_ck, dq_oe, dm_oe, dqs_o, dqs_oe, busy, done;
  logic [15:0] dq_o;
  logic [1:0]  dm_o;
  logic [9:0]  beat_col;
  logic [1:0]  beat_bank;

  int n_total;
  int n_fail;

  ddr_wr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_bl_code(mode_bl_code),
    .cmd_wr(cmd_wr), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .wr_data(wr_data), .wr_mask(wr_mask), .wr_ready(wr_ready), .mem_ck(mem_ck),
    .dq_o(dq_o), .dq_oe(dq_oe), .dm_o(dm_o), .dm_oe(dm_oe),
    .dqs_o(dqs_o), .dqs_oe(dqs_oe), .beat_col(beat_col), .beat_bank(beat_bank),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input int id, input int k);
    return 16'(16'h5a00 ^ ((id & 8'hff) << 8) ^ (k * 16'h0013));
  endfunction

  function automatic logic [1:0] mask_of(input int id, input int k);
    return 2'(id + k);
  endfunction

  task automatic set_mode(input logic [2:0] code);
    @(negedge clk);
    mode_we = 1'b1;
    mode_bl_code = code;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  // Runs one burst from command to the idle tick after done and checks it.
  task automatic do_burst(input int bl, input logic [1:0] bank, input logic [9:0] col,
                          input bit hammer, input int id);
    logic [9:0] exp_col;
    @(negedge clk);
    while (mem_ck !== 1'b1) @(negedge clk);
    cmd_wr = 1'b1; cmd_bank = bank; cmd_col = col;
    @(negedge clk);
    if (hammer) begin cmd_bank = ~bank; cmd_col = ~col; end
    else cmd_wr = 1'b0;
    chk("R2 busy after accept", busy, 1);
    chk("R4 preamble dqs_oe", dqs_oe, 1);
    chk("R4 preamble dqs low", dqs_o, 0);
    chk("R4 preamble dq_oe", dq_oe, 0);
    chk("R7 ready in preamble", wr_ready, 1);
    wr_data = word_of(id, 0); wr_mask = mask_of(id, 0);
    for (int k = 0; k < bl; k++) begin
      @(negedge clk);
      exp_col = (col & ~10'(bl - 1)) | (10'(col + 10'(k)) & 10'(bl - 1));
      if (k == 0) chk("R3 first beat on mem_ck high", mem_ck, 1);
      chk("R3 dq_oe in beat", dq_oe, 1);
      chk("R3 dqs level per beat", dqs_o, ((k % 2) == 0) ? 1 : 0);
      chk("R6 data beat", dq_o, word_of(id, k));
      chk("R6 mask beat", dm_o, mask_of(id, k));
      chk("R6 dm_oe", dm_oe, 1);
      chk("R8 column order", beat_col, exp_col);
      chk(hammer ? "R9 bank kept under new command" : "R8 bank held", beat_bank, bank);
      chk("R7 ready per beat", wr_ready, (k < bl - 1) ? 1 : 0);
      wr_data = word_of(id, k + 1); wr_mask = mask_of(id, k + 1);
    end
    @(negedge clk);
    chk("R5 postamble dqs_oe", dqs_oe, 1);
    chk("R5 postamble dqs low", dqs_o, 0);
    chk("R5 postamble dq_oe", dq_oe, 0);
    chk("R7 no ready in postamble", wr_ready, 0);
    chk("R2 busy in postamble", busy, 1);
    @(negedge clk);
    cmd_wr = 1'b0;
    chk("R10 done pulse", done, 1);
    chk("R10 busy low at done", busy, 0);
    chk("R5 strobe released", dqs_oe, 0);
    chk("R5 data released", dq_oe, 0);
    chk("R5 mask released", dm_oe, 0);
    @(negedge clk);
    chk("R10 done one tick", done, 0);
    chk(hammer ? "R9 no restart" : "R2 idle after burst", busy, 0);
  endtask

  task automatic reject_low_phase();
    @(negedge clk);
    while (mem_ck !== 1'b0) @(negedge clk);
    cmd_wr = 1'b1; cmd_bank = 2'd1; cmd_col = 10'd5;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk("R9 low mem_ck command ignored", busy, 0);
    @(negedge clk);
    chk("R9 still idle", busy, 0);
    chk("R2 mem_ck toggles", mem_ck, 0);
  endtask

  task automatic reset_check();
    repeat (3) @(negedge clk);
    chk("R11 dqs_oe in reset", dqs_oe, 0);
    chk("R11 dq_oe in reset", dq_oe, 0);
    chk("R11 dm_oe in reset", dm_oe, 0);
    chk("R11 busy in reset", busy, 0);
    chk("R11 done in reset", done, 0);
    chk("R11 ready in reset", wr_ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 idle after reset", {busy, dqs_oe, dq_oe}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_total++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    n_total = 0; n_fail = 0;
    rst_n = 1'b0; mode_we = 1'b0; mode_bl_code = 3'b000;
    cmd_wr = 1'b0; cmd_bank = '0; cmd_col = '0; wr_data = '0; wr_mask = '0;
    reset_check();
    // R1 reset length is 4, mid-block start
    do_burst(4, 2'd2, 10'd2, 1'b0, 1);
    // R1 length 8 with wrap from the last slot of a block
    set_mode(3'b011);
    do_burst(8, 2'd3, 10'h0f7, 1'b0, 2);
    // R1 invalid codes keep 8
    set_mode(3'b111);
    set_mode(3'b000);
    do_burst(8, 2'd1, 10'h3f0, 1'b0, 3);
    // R9 command held through the burst
    do_burst(8, 2'd0, 10'd13, 1'b1, 4);
    reject_low_phase();
    // R1 length 2, back to back
    set_mode(3'b001);
    do_burst(2, 2'd1, 10'd3, 1'b0, 5);
    do_burst(2, 2'd2, 10'd8, 1'b0, 6);
    set_mode(3'b100);
    do_burst(2, 2'd3, 10'h3ff, 1'b0, 7);
    set_mode(3'b010);
    do_burst(4, 2'd0, 10'd7, 1'b0, 8);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule